// File: doc/BRIEF.md
# Command-driven SPI transfer engine

This block is an SPI master that executes one command at a time. A command names the peripherals to select, the bit order, a header of zero, one or two bytes taken from a 16-bit header value, a direction and a body length. A write shifts out the header and then body bytes pulled one at a time from a byte-wide input handshake. A read shifts out the header and then clocks in the requested number of body bytes from the return line, presenting each finished byte on a one-cycle output strobe.

The bus runs in SPI mode 0. The serial clock is the system clock divided by `CLK_DIV` (even, at least 2). Commands are presented with a one-cycle valid. They are taken only while the engine is idle. Illegal commands produce a single error pulse and no bus activity. `busy_o` and `done_o` let a controller sequence commands back to back.

Top module: `spi_cmd_engine`

## Requirements
- R1: `spi_sel_no[i]` is driven low for the whole transfer exactly when bit i of the accepted select mask is 1, for all eight bits including bit 3. All selects are high while idle.
- R2: Format byte: bit 7 = 1 gives least-significant-bit first and 0 gives most-significant-bit first. Bits 6:5 give the header byte count 0, 1 or 2. A count of 3 is rejected with an error.
- R3: A body length above `MAX_LEN` (64) is rejected. `err_o` pulses for exactly one cycle, no select asserts, no clock edge occurs and `done_o` does not pulse. A length of exactly 64 is accepted.
- R4: A read whose mask has more than one bit set is rejected like R3. Writes may select any number of peripherals.
- R5: With one header byte, the low byte of the header value is sent. With two, MSB-first order sends the high byte then the low byte, and LSB-first order sends the low byte then the high byte. Each byte goes out in the command's bit order.
- R6: A write sends the header and then `cmd_len_i` body bytes. Each body byte is taken when `wr_valid_i` and `wr_ready_o` are both high. The select mask stays unchanged from the first to the last bit. A late `wr_valid_i` holds the clock low.
- R7: A read sends the header and then clocks `cmd_len_i` bytes in from `spi_miso_i` while `spi_mosi_o` is 0. Each byte appears on `rd_data_o` with a one-cycle `rd_valid_o`, assembled in the command's bit order.
- R8: The serial clock idles low. Each high phase lasts `CLK_DIV/2` system cycles. `spi_mosi_o` changes only while the clock is low, and `spi_miso_i` is sampled at the rising edge.
- R9: Selects assert at least `CLK_DIV/2` cycles before the first rising edge. They stay asserted at least `CLK_DIV/2` cycles after the last falling edge.
- R10: `busy_o` rises the cycle after a legal command is taken. `done_o` pulses for one cycle at the end. `cmd_valid_i` is ignored while busy. A command with zero total bytes completes with `done_o` and no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present (one cycle) |
| cmd_sel_i | input | 8 | Peripheral select mask, active high |
| cmd_fmt_i | input | 8 | Bit 7 bit order, bits 6:5 header count |
| cmd_hdr_i | input | 16 | Header value |
| cmd_rd_i | input | 1 | 1 = read, 0 = write |
| cmd_len_i | input | 8 | Body length in bytes |
| wr_data_i | input | 8 | Write body byte |
| wr_valid_i | input | 1 | Write byte available |
| wr_ready_o | output | 1 | Engine takes write byte this cycle |
| rd_data_o | output | 8 | Received body byte |
| rd_valid_o | output | 1 | Received byte strobe |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished pulse |
| err_o | output | 1 | Command rejected pulse |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Master-to-peripheral data |
| spi_miso_i | input | 1 | Peripheral-to-master data |
| spi_sel_no | output | 8 | Per-peripheral selects, active low |

## Verification
The bench aims at the two-byte header ordering under each bit order. A design that ignores the order flag for byte selection sends the bytes swapped under LSB-first. The bench decodes received read bytes in both orders, which catches a design that shifts the return line in from the wrong end. It rejects a header count of 3, a length of 65, and a read selecting two peripherals, and it requires exactly one error cycle, no clock and no select; a design that checks the limit as 64 exclusive, or starts the bus before deciding, fails there. It starves the write handshake and fires commands while busy, which catches a design that drops selects between bytes or restarts on a second valid.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_LOW, ST_HIGH, ST_TAIL, ST_FIN
  } spi_state_e;

  localparam int unsigned FMT_ORDER_BIT = 7;
  localparam int unsigned FMT_HDR_LO    = 5;
  localparam int unsigned SEL_W         = 8;
endpackage

// File: rtl/spi_cmd_check.sv
module spi_cmd_check
  import spi_cmd_pkg::*;
#(
  parameter int unsigned MAX_LEN = 64,
  parameter int unsigned LEN_W   = 8
) (
  input  logic [7:0]       fmt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rd_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [15:0]      hdr_i,
  output logic             bad_o,
  output logic             lsb_o,
  output logic [1:0]       hdr_n_o,
  output logic [15:0]      hq_o
);
  logic [1:0] hcnt;
  logic       multi;

  assign hcnt    = fmt_i[FMT_HDR_LO +: 2];
  assign lsb_o   = fmt_i[FMT_ORDER_BIT];
  assign multi   = (sel_i & (sel_i - SEL_W'(1))) != '0;
  assign bad_o   = (hcnt == 2'd3) || (len_i > LEN_W'(MAX_LEN)) || (rd_i && multi);
  assign hdr_n_o = (hcnt == 2'd3) ? 2'd0 : hcnt;

  // hq_o[7:0] is the first byte to send, hq_o[15:8] the second
  always_comb begin
    unique case (hcnt)
      2'd1:    hq_o = {8'h00, hdr_i[7:0]};
      2'd2:    hq_o = lsb_o ? hdr_i : {hdr_i[7:0], hdr_i[15:8]};
      default: hq_o = 16'h0000;
    endcase
  end
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int unsigned HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  assert_cnt_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= HALF - 1);
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lsb_i,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  input  logic       shift_i,
  input  logic       sample_i,
  input  logic       miso_i,
  output logic       mosi_o,
  output logic [7:0] rx_o
);
  logic [7:0] tx_q, rx_q;

  assign mosi_o = lsb_i ? tx_q[0] : tx_q[7];
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)       tx_q <= load_byte_i;
      else if (shift_i) tx_q <= lsb_i ? {1'b0, tx_q[7:1]} : {tx_q[6:0], 1'b0};
      if (sample_i)     rx_q <= lsb_i ? {miso_i, rx_q[7:1]} : {rx_q[6:0], miso_i};
    end
  end

  assert_load_shift_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned MAX_LEN = 64,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [SEL_W-1:0] cmd_sel_i,
  input  logic [7:0]       cmd_fmt_i,
  input  logic [15:0]      cmd_hdr_i,
  input  logic             cmd_rd_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             spi_sclk_o,
  output logic             spi_mosi_o,
  input  logic             spi_miso_i,
  output logic [SEL_W-1:0] spi_sel_no
);
  localparam int unsigned HALF = CLK_DIV / 2;

  spi_state_e       state_q;
  logic [SEL_W-1:0] sel_q;
  logic             lsb_q, rd_q, cur_rd_q, err_q, rd_valid_q;
  logic [15:0]      hq_q;
  logic [1:0]       hdr_left_q;
  logic [LEN_W-1:0] bytes_left_q, total;
  logic [2:0]       bit_q;

  logic        chk_bad, chk_lsb;
  logic [1:0]  chk_hdr_n;
  logic [15:0] chk_hq;
  logic        tick, run, on_bus;
  logic        ld, shift, sample;
  logic [7:0]  ld_byte;

  spi_cmd_check #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
    .fmt_i(cmd_fmt_i), .sel_i(cmd_sel_i), .rd_i(cmd_rd_i), .len_i(cmd_len_i),
    .hdr_i(cmd_hdr_i), .bad_o(chk_bad), .lsb_o(chk_lsb), .hdr_n_o(chk_hdr_n),
    .hq_o(chk_hq)
  );

  assign run    = (state_q == ST_LOW) || (state_q == ST_HIGH) || (state_q == ST_TAIL);
  assign on_bus = run || (state_q == ST_LOAD);
  assign total  = LEN_W'(chk_hdr_n) + cmd_len_i;

  spi_half_timer #(.HALF(HALF)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .last_o(tick)
  );

  assign wr_ready_o = (state_q == ST_LOAD) && (hdr_left_q == 2'd0) && !rd_q;
  assign ld         = (state_q == ST_LOAD) && ((hdr_left_q != 2'd0) || rd_q || wr_valid_i);
  assign ld_byte    = (hdr_left_q != 2'd0) ? hq_q[7:0] : (rd_q ? 8'h00 : wr_data_i);
  assign shift      = (state_q == ST_HIGH) && tick && (bit_q != 3'd7);
  assign sample     = (state_q == ST_LOW) && tick;

  spi_byte_shifter u_shf (
    .clk_i(clk_i), .rst_ni(rst_ni), .lsb_i(lsb_q), .load_i(ld), .load_byte_i(ld_byte),
    .shift_i(shift), .sample_i(sample), .miso_i(spi_miso_i), .mosi_o(spi_mosi_o),
    .rx_o(rd_data_o)
  );

  assign spi_sel_no = on_bus ? ~sel_q : '1;
  assign spi_sclk_o = (state_q == ST_HIGH);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);
  assign err_o      = err_q;
  assign rd_valid_o = rd_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      sel_q        <= '0;
      lsb_q        <= 1'b0;
      rd_q         <= 1'b0;
      cur_rd_q     <= 1'b0;
      hq_q         <= '0;
      hdr_left_q   <= '0;
      bytes_left_q <= '0;
      bit_q        <= '0;
      err_q        <= 1'b0;
      rd_valid_q   <= 1'b0;
    end else begin
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          if (chk_bad) err_q <= 1'b1;
          else begin
            sel_q        <= cmd_sel_i;
            lsb_q        <= chk_lsb;
            rd_q         <= cmd_rd_i;
            hq_q         <= chk_hq;
            hdr_left_q   <= chk_hdr_n;
            bytes_left_q <= total;
            bit_q        <= '0;
            state_q      <= (total == '0) ? ST_FIN : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (hdr_left_q != 2'd0) begin
            hq_q       <= {8'h00, hq_q[15:8]};
            hdr_left_q <= hdr_left_q - 2'd1;
            cur_rd_q   <= 1'b0;
            state_q    <= ST_LOW;
          end else if (rd_q) begin
            cur_rd_q <= 1'b1;
            state_q  <= ST_LOW;
          end else if (wr_valid_i) begin
            cur_rd_q <= 1'b0;
            state_q  <= ST_LOW;
          end
        end
        ST_LOW: if (tick) state_q <= ST_HIGH;
        ST_HIGH: if (tick) begin
          if (bit_q == 3'd7) begin
            bit_q        <= '0;
            rd_valid_q   <= cur_rd_q;
            bytes_left_q <= bytes_left_q - LEN_W'(1);
            state_q      <= (bytes_left_q == LEN_W'(1)) ? ST_TAIL : ST_LOAD;
          end else begin
            bit_q   <= bit_q + 3'd1;
            state_q <= ST_LOW;
          end
        end
        ST_TAIL: if (tick) state_q <= ST_FIN;
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_sel_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (spi_sel_no == '1));
  assert_err_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && spi_sel_no == '1 && !spi_sclk_o));
  assert_rd_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_q) |-> $onehot0(~spi_sel_no));
  assert_sel_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !done_o) |-> $stable(spi_sel_no));
  assert_mosi_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_sclk_o && $past(spi_sclk_o)) |-> $stable(spi_mosi_o));
  assert_sclk_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sclk_o |-> busy_o);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0, cmd_rd_i = 1'b0;
  logic [7:0] cmd_sel_i = '0, cmd_fmt_i = '0, cmd_len_i = '0;
  logic [15:0] cmd_hdr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic wr_valid_i = 1'b0;
  logic wr_ready_o, rd_valid_o, busy_o, done_o, err_o, spi_sclk_o, spi_mosi_o, spi_miso_i;
  logic [7:0] rd_data_o, spi_sel_no;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(DIV), .MAX_LEN(64)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_sel_i(cmd_sel_i),
    .cmd_fmt_i(cmd_fmt_i), .cmd_hdr_i(cmd_hdr_i), .cmd_rd_i(cmd_rd_i), .cmd_len_i(cmd_len_i),
    .wr_data_i(wr_data_i), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .spi_sclk_o(spi_sclk_o), .spi_mosi_o(spi_mosi_o),
    .spi_miso_i(spi_miso_i), .spi_sel_no(spi_sel_no)
  );

  int total_n = 0, bad_n = 0, cyc = 0;
  logic mbit[0:1023];
  logic sbit[0:1023];
  int mcnt = 0;
  logic [7:0] wbuf[0:127];
  logic [7:0] rbuf[0:127];
  logic [7:0] ebuf[0:127];
  int widx = 0, wgap = 0, wstall = 0, rd_n = 0, done_n = 0, err_n = 0, viol = 0;
  bit wtake = 0;
  logic [7:0] sel_seen = '0;
  int lead = 0, tail = 0, hi_len = 0;
  bit seen_rise = 0, prev_act = 0, prev_sclk = 0, prev_mosi = 0, busy_after = 0;

  assign spi_miso_i = (mcnt < 1024) ? sbit[mcnt] : 1'b0;

  always @(posedge spi_sclk_o) begin
    if (mcnt < 1024) mbit[mcnt] = spi_mosi_o;
    mcnt++;
  end

  always @(negedge clk) begin
    if (wtake) begin widx++; wstall = wgap; wtake = 0; end
    else if (wstall > 0) wstall--;
    wr_valid_i = (wstall == 0);
    wr_data_i  = wbuf[widx[6:0]];
    if (wr_valid_i && wr_ready_o) wtake = 1;
  end

  always @(negedge clk) begin
    bit act;
    cyc++;
    act = (spi_sel_no != 8'hFF);
    sel_seen |= ~spi_sel_no;
    if (rd_valid_o && rd_n < 128) begin rbuf[rd_n] = rd_data_o; rd_n++; end
    if (done_o) done_n++;
    if (err_o) err_n++;
    if (act && !spi_sclk_o && !seen_rise) lead++;
    if (spi_sclk_o && !prev_sclk) begin
      if (!seen_rise && lead < HALF) viol++;
      seen_rise = 1; hi_len = 0; tail = 0;
    end
    if (spi_sclk_o) hi_len++;
    if (!spi_sclk_o && prev_sclk && hi_len != HALF) viol++;
    if (spi_sclk_o && prev_sclk && spi_mosi_o != prev_mosi) viol++;
    if (act && !spi_sclk_o && seen_rise) tail++;
    if (!act && prev_act) begin
      if (seen_rise && tail < HALF) viol++;
      seen_rise = 0; lead = 0;
    end
    if (!act && spi_sclk_o) viol++;
    prev_act = act; prev_sclk = spi_sclk_o; prev_mosi = spi_mosi_o;
    if (cyc == 150000) begin
      total_n++; bad_n++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mosi_byte(int j, bit lsb);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (lsb) r[i] = mbit[8*j+i];
      else     r[7-i] = mbit[8*j+i];
    end
    return r;
  endfunction

  task automatic set_reply(int pos, logic [7:0] v, bit lsb);
    for (int i = 0; i < 8; i++) sbit[8*pos+i] = lsb ? v[i] : v[7-i];
  endtask

  task automatic clear_mon();
    mcnt = 0; rd_n = 0; done_n = 0; err_n = 0; viol = 0; widx = 0; sel_seen = '0;
    for (int i = 0; i < 1024; i++) sbit[i] = 1'b0;
  endtask

  task automatic issue(logic [7:0] sel, logic [7:0] fmt, logic [15:0] hdr, bit rd, int len);
    cmd_sel_i = sel; cmd_fmt_i = fmt; cmd_hdr_i = hdr; cmd_rd_i = rd; cmd_len_i = 8'(len);
    cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    busy_after = busy_o;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000 && done_n == 0 && err_n == 0; i++) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic run_cmd(logic [7:0] sel, logic [7:0] fmt, logic [15:0] hdr, bit rd, int len);
    @(negedge clk);
    issue(sel, fmt, hdr, rd, len);
    wait_end();
  endtask

  task automatic check_tx(string req, int n, bit lsb);
    check(mcnt == n * 8, req, "bit count", mcnt, n * 8);
    for (int j = 0; j < n; j++) check(mosi_byte(j, lsb) === ebuf[j], req, "tx byte", mosi_byte(j, lsb), ebuf[j]);
  endtask

  task automatic check_ok_end(string req, logic [7:0] sel);
    check(done_n == 1, "R10", "done pulses", done_n, 1);
    check(err_n == 0, req, "no error", err_n, 0);
    check(sel_seen == sel, "R1", "select seen", sel_seen, sel);
    check(viol == 0, "R8/R9", "timing violations", viol, 0);
  endtask

  task automatic t_reset();
    check(spi_sel_no == 8'hFF, "R1", "reset selects", spi_sel_no, 8'hFF);
    check(!spi_sclk_o && !busy_o && !done_o && !err_o, "R10", "reset outputs",
          {spi_sclk_o, busy_o, done_o, err_o}, 0);
  endtask

  // R5 R6: write, two-byte header MSB-first, reserved select bit 3
  task automatic t_write_msb();
    clear_mon(); wgap = 0;
    wbuf[0] = 8'h3C; wbuf[1] = 8'h81;
    ebuf[0] = 8'h12; ebuf[1] = 8'hC4; ebuf[2] = 8'h3C; ebuf[3] = 8'h81;
    run_cmd(8'h08, 8'h40, 16'h12C4, 1'b0, 2);
    check(busy_after, "R10", "busy after accept", busy_after, 1);
    check_tx("R5", 4, 1'b0);
    check_ok_end("R6", 8'h08);
  endtask

  // R5 R6 R4: write LSB-first, all selects, stalled data
  task automatic t_write_lsb_stall();
    clear_mon(); wgap = 5;
    wbuf[0] = 8'hF0; wbuf[1] = 8'h0B; wbuf[2] = 8'h77;
    ebuf[0] = 8'hC4; ebuf[1] = 8'h12; ebuf[2] = 8'hF0; ebuf[3] = 8'h0B; ebuf[4] = 8'h77;
    run_cmd(8'hFF, 8'hC0, 16'h12C4, 1'b0, 3);
    check_tx("R6", 5, 1'b1);
    check_ok_end("R4", 8'hFF);
    wgap = 0;
  endtask

  // R5: single header byte, no body
  task automatic t_hdr_only();
    clear_mon();
    ebuf[0] = 8'h66;
    run_cmd(8'h01, 8'h20, 16'h9966, 1'b0, 0);
    check_tx("R5", 1, 1'b0);
    check_ok_end("R5", 8'h01);
  endtask

  // R7: read MSB-first
  task automatic t_read_msb();
    logic [7:0] rep[4] = '{8'hD2, 8'h1F, 8'h80, 8'h6B};
    clear_mon();
    for (int k = 0; k < 4; k++) begin set_reply(1 + k, rep[k], 1'b0); ebuf[1+k] = 8'h00; end
    ebuf[0] = 8'h85;
    run_cmd(8'h20, 8'h20, 16'h0085, 1'b1, 4);
    check_tx("R7", 5, 1'b0);
    check(rd_n == 4, "R7", "read strobes", rd_n, 4);
    for (int k = 0; k < 4; k++) check(rbuf[k] === rep[k], "R7", "read byte", rbuf[k], rep[k]);
    check_ok_end("R7", 8'h20);
  endtask

  // R7 R2: read LSB-first with two header bytes
  task automatic t_read_lsb();
    logic [7:0] rep[2] = '{8'h01, 8'hE4};
    clear_mon();
    for (int k = 0; k < 2; k++) begin set_reply(2 + k, rep[k], 1'b1); ebuf[2+k] = 8'h00; end
    ebuf[0] = 8'h3C; ebuf[1] = 8'h5A;
    run_cmd(8'h80, 8'hC0, 16'h5A3C, 1'b1, 2);
    check_tx("R2", 4, 1'b1);
    check(rd_n == 2, "R7", "read strobes", rd_n, 2);
    for (int k = 0; k < 2; k++) check(rbuf[k] === rep[k], "R7", "lsb read byte", rbuf[k], rep[k]);
    check_ok_end("R7", 8'h80);
  endtask

  task automatic expect_reject(string req, logic [7:0] sel, logic [7:0] fmt, bit rd, int len);
    clear_mon();
    run_cmd(sel, fmt, 16'hFFFF, rd, len);
    check(err_n == 1, req, "error pulse cycles", err_n, 1);
    check(done_n == 0 && mcnt == 0 && sel_seen == 8'h00, req, "bus quiet",
          done_n + mcnt + int'(sel_seen), 0);
  endtask

  task automatic t_errors();
    expect_reject("R2", 8'h01, 8'h60, 1'b0, 1);
    expect_reject("R3", 8'h01, 8'h00, 1'b0, 65);
    expect_reject("R4", 8'h03, 8'h00, 1'b1, 1);
  endtask

  // R3: boundary length accepted
  task automatic t_len64();
    clear_mon();
    for (int k = 0; k < 64; k++) begin wbuf[k] = 8'(k * 3 + 1); ebuf[k] = 8'(k * 3 + 1); end
    run_cmd(8'h04, 8'h00, 16'h0000, 1'b0, 64);
    check_tx("R3", 64, 1'b0);
    check_ok_end("R3", 8'h04);
  endtask

  // R10: zero total bytes
  task automatic t_zero();
    clear_mon();
    run_cmd(8'h02, 8'h00, 16'h0000, 1'b0, 0);
    check(done_n == 1 && mcnt == 0 && sel_seen == 8'h00, "R10", "empty command",
          done_n * 16 + mcnt, 16);
  endtask

  // R10: commands while busy are ignored
  task automatic t_busy_ignore();
    clear_mon(); wgap = 3;
    wbuf[0] = 8'hA7; wbuf[1] = 8'h4E;
    ebuf[0] = 8'hA7; ebuf[1] = 8'h4E;
    @(negedge clk);
    issue(8'h02, 8'h00, 16'h0000, 1'b0, 2);
    repeat (6) @(negedge clk);
    check(busy_o, "R10", "busy mid transfer", busy_o, 1);
    issue(8'h03, 8'h60, 16'h1234, 1'b1, 70);
    repeat (4) @(negedge clk);
    issue(8'h40, 8'h20, 16'h00EE, 1'b0, 0);
    wait_end();
    check_tx("R10", 2, 1'b0);
    check_ok_end("R10", 8'h02);
    wgap = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_msb();
    t_write_lsb_stall();
    t_hdr_only();
    t_read_msb();
    t_read_lsb();
    t_errors();
    t_len64();
    t_zero();
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule